// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block holds the modem control and modem status registers of a 16550-style serial port. The control register drives four handshake outputs (request-to-send, terminal-ready and two general-purpose outputs) and carries a loopback switch. The status register tracks four incoming modem lines (clear-to-send, data-set-ready, ring and carrier) once per clock. It keeps a sticky change flag for each line, and the flags are cleared when software reads the register.

A host reaches both registers over a small byte-wide bus with one-cycle write and read strobes, and read data is registered. When loopback is set, the outputs go quiet and a status read shows the control bits in place of the external lines. A modem-status interrupt request is raised while the external enable input is high and any change flag is set. The line inputs must already be synchronised to `clk`.

Top module: `modem_line_unit`

## Requirements
- R1: After a synchronous reset the control register reads 0x08 (only the OUT2 bit set), the status register reads 0xB0, `pin_out2` is 1, the other three pins are 0 and `irq` is 0.
- R2: A write to address CTRL_ADDR (default 0) stores `wr_data[4:0]`, laid out as bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. A read of that address returns the stored value with bits 7..5 as 0.
- R3: Outside loopback, `pin_dtr`, `pin_rts`, `pin_out1` and `pin_out2` are active-high copies of control bits 0..3. They change at the same clock edge that takes the write.
- R4: A read of address STAT_ADDR (default 1) returns the line state in bits 7..4: bit 7 carrier (`line_dcd`), bit 6 ring (`line_ri`), bit 5 `line_dsr`, bit 4 `line_cts`. The line state is sampled on every edge outside loopback, and a read returns the contents held before that read's edge.
- R5: Outside loopback, the change flags are bit 3 (carrier), bit 1 (DSR) and bit 0 (CTS). Each is set when its sampled line differs from the stored state, and it then stays set until cleared.
- R6: Change flag bit 2 is set only when the ring line goes from 1 to 0. A 0-to-1 change of the ring line leaves it unchanged.
- R7: A status read outside loopback clears all four change flags and leaves the line-state bits alone. A line change sampled at the same edge as the read sets its flag anew.
- R8: In loopback, a status read returns OUT2 as bit 7, OUT1 as bit 6, DTR as bit 5, RTS as bit 4 and 0 in bits 3..0. While loopback lasts, the stored line state and change flags are frozen. External line changes are ignored, and a read does not clear the flags.
- R9: While loopback is set, all four output pins are driven to 0.
- R10: `irq` is 1 exactly when `msi_en` was high at the last edge and any change flag is set after that edge.
- R11: Writes to STAT_ADDR or to unused addresses change nothing, and reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| msi_en | input | 1 | Modem-status interrupt enable |
| line_cts | input | 1 | Clear-to-send line, active high |
| line_dsr | input | 1 | Data-set-ready line, active high |
| line_ri | input | 1 | Ring line, active high |
| line_dcd | input | 1 | Carrier line, active high |
| pin_dtr | output | 1 | Terminal-ready output |
| pin_rts | output | 1 | Request-to-send output |
| pin_out1 | output | 1 | General output 1 |
| pin_out2 | output | 1 | General output 2 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
Every result is due at the first rising edge after its stimulus: the output pins after a control write, `rd_data` after a read strobe, the line state and change flags after a line change, and `irq` after a flag or enable change. The bench drives each stimulus at a falling edge and updates its reference model for exactly one edge. It compares at the following falling edge, so each comparison sees the single register stage the requirement implies. A read strobe and a line change given together check that `rd_data` carries the pre-edge contents while the flags already show the new change.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int CTRL_W  = 5;
  localparam int LINES_W = 4;

  // nibble positions of the modem lines
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
  localparam logic [LINES_W-1:0] LINES_RST = 4'b1011;

  // line nibble presented while looped back
  function automatic logic [LINES_W-1:0] loop_lines(input ctrl_t c);
    logic [LINES_W-1:0] n;
    n[LN_DCD] = c.out2;
    n[LN_RI]  = c.out1;
    n[LN_DSR] = c.dtr;
    n[LN_CTS] = c.rts;
    return n;
  endfunction
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              pin_dtr,
  output logic              pin_rts,
  output logic              pin_out1,
  output logic              pin_out2
);
  ctrl_t ctrl_nxt;
  logic  hit;

  assign hit = wr_en && (addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (hit) ctrl_nxt = ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      pin_dtr  <= CTRL_RST.dtr;
      pin_rts  <= CTRL_RST.rts;
      pin_out1 <= CTRL_RST.out1;
      pin_out2 <= CTRL_RST.out2;
    end else begin
      ctrl_q   <= ctrl_nxt;
      pin_dtr  <= ctrl_nxt.dtr  && !ctrl_nxt.loop;
      pin_rts  <= ctrl_nxt.rts  && !ctrl_nxt.loop;
      pin_out1 <= ctrl_nxt.out1 && !ctrl_nxt.loop;
      pin_out2 <= ctrl_nxt.out2 && !ctrl_nxt.loop;
    end
  end
endmodule

// File: rtl/mdm_status_track.sv
module mdm_status_track
  import mdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               freeze,
  input  logic               clr,
  input  logic [LINES_W-1:0] lines,
  output logic [LINES_W-1:0] state_q,
  output logic [LINES_W-1:0] delta_q,
  output logic [LINES_W-1:0] delta_nxt
);
  logic [LINES_W-1:0] chg;
  logic [LINES_W-1:0] hit;
  logic [LINES_W-1:0] state_nxt;

  assign chg = lines ^ state_q;

  for (genvar i = 0; i < LINES_W; i++) begin : g_flag
    if (i == LN_RI) begin : g_trail
      assign hit[i] = chg[i] && state_q[i];
    end else begin : g_any
      assign hit[i] = chg[i];
    end
  end

  always_comb begin
    if (freeze) begin
      state_nxt = state_q;
      delta_nxt = delta_q;
    end else begin
      state_nxt = lines;
      delta_nxt = (clr ? '0 : delta_q) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LINES_RST;
      delta_q <= '0;
    end else begin
      state_q <= state_nxt;
      delta_q <= delta_nxt;
    end
  end
endmodule

// File: rtl/mdm_read_port.sv
module mdm_read_port
  import mdm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  ctrl_t              ctrl_q,
  input  logic [LINES_W-1:0] state_q,
  input  logic [LINES_W-1:0] delta_q,
  output logic [DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      mux = DATA_W'(ctrl_q);
    end else if (addr == ADDR_W'(STAT_ADDR)) begin
      if (ctrl_q.loop) mux = DATA_W'({loop_lines(ctrl_q), {LINES_W{1'b0}}});
      else             mux = DATA_W'({state_q, delta_q});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mux;
  end
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
  import mdm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              msi_en,
  input  logic              line_cts,
  input  logic              line_dsr,
  input  logic              line_ri,
  input  logic              line_dcd,
  output logic              pin_dtr,
  output logic              pin_rts,
  output logic              pin_out1,
  output logic              pin_out2,
  output logic              irq
);
  ctrl_t              ctrl_q;
  logic [LINES_W-1:0] lines;
  logic [LINES_W-1:0] state_q;
  logic [LINES_W-1:0] delta_q;
  logic [LINES_W-1:0] delta_nxt;
  logic               stat_rd;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:CTRL_W];

  always_comb begin
    lines         = '0;
    lines[LN_CTS] = line_cts;
    lines[LN_DSR] = line_dsr;
    lines[LN_RI]  = line_ri;
    lines[LN_DCD] = line_dcd;
  end

  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));

  mdm_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(wr_data[CTRL_W-1:0]), .ctrl_q(ctrl_q),
    .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2)
  );

  mdm_status_track u_stat (
    .clk(clk), .rst(rst), .freeze(ctrl_q.loop), .clr(stat_rd),
    .lines(lines), .state_q(state_q), .delta_q(delta_q), .delta_nxt(delta_nxt)
  );

  mdm_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
                  .STAT_ADDR(STAT_ADDR)) u_rd (
    .clk(clk), .rst(rst), .rd_en(reg_rd), .addr(reg_addr), .ctrl_q(ctrl_q),
    .state_q(state_q), .delta_q(delta_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= msi_en && (delta_nxt != '0);
  end
endmodule

// File: rtl/modem_line_chk.sv
module modem_line_chk #(
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [4:0]        ctrl_bits,
  input logic [3:0]        lines,
  input logic [3:0]        state_q,
  input logic [3:0]        delta_q,
  input logic              pin_dtr,
  input logic              pin_rts,
  input logic              pin_out1,
  input logic              pin_out2,
  input logic              irq
);
  logic stat_rd;
  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out2 && !pin_out1 && !pin_rts && !pin_dtr && !irq)); // R1

  AST_PINS_FOLLOW_CTRL: assert property (@(posedge clk) disable iff (rst)
    !ctrl_bits[4] |-> ({pin_out2, pin_out1, pin_rts, pin_dtr} == ctrl_bits[3:0])); // R3

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
    ctrl_bits[4] |-> !(pin_out2 || pin_out1 || pin_rts || pin_dtr)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_bits[4] && !stat_rd && (lines == state_q)) |=> (delta_q == $past(delta_q))); // R5

  AST_RING_TRAIL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (delta_q[2] && !$past(delta_q[2])) |-> ($past(state_q[2]) && !state_q[2])); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !ctrl_bits[4] && (lines == state_q)) |=> (delta_q == 4'b0)); // R7

  AST_LOOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits[4] && $past(ctrl_bits[4])) |-> ($stable(state_q) && $stable(delta_q))); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> (delta_q != 4'b0)); // R10
endmodule

bind modem_line_unit modem_line_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .ctrl_bits(ctrl_q), .lines(lines), .state_q(state_q), .delta_q(delta_q),
  .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2),
  .irq(irq)
);

// File: tb/tb_modem_line_unit.sv
`timescale 1ns/1ps
module tb_modem_line_unit;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0, msi_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic line_cts = 1'b1, line_dsr = 1'b1, line_ri = 1'b0, line_dcd = 1'b1;
  logic pin_dtr, pin_rts, pin_out1, pin_out2, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [4:0] m_ctrl;
  logic [3:0] m_st;
  logic [3:0] m_dl;

  always #4 clk = ~clk;

  modem_line_unit dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .msi_en(msi_en),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
    .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    if (a == A_CTRL) return {3'b0, m_ctrl};
    if (a == A_STAT) begin
      if (m_ctrl[4]) return {m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1], 4'b0};
      return {m_st, m_dl};
    end
    return 8'h00;
  endfunction

  // one clock: drive at falling edge, model one rising edge, compare at next falling edge
  task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [7:0] wd, input logic [3:0] ln, input logic msi);
    logic [7:0] erd;
    logic [3:0] x, fl;
    reg_wr = wr; reg_rd = rd; reg_addr = a; wr_data = wd; msi_en = msi;
    {line_dcd, line_ri, line_dsr, line_cts} = ln;
    erd = exp_read(a);
    if (!m_ctrl[4]) begin
      x  = ln ^ m_st;
      fl = {x[3], x[2] & m_st[2], x[1], x[0]};
      m_dl = ((rd && a == A_STAT) ? 4'b0 : m_dl) | fl;
      m_st = ln;
    end
    if (wr && a == A_CTRL) m_ctrl = wd[4:0];
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    if (m_ctrl[4]) chk("R9 pins in loopback", {pin_out2, pin_out1, pin_rts, pin_dtr}, 4'b0);
    else chk("R3 pins", {pin_out2, pin_out1, pin_rts, pin_dtr}, m_ctrl[3:0]);
    chk("R10 irq", irq, msi && (m_dl != 4'b0));
    if (rd) begin
      if (a == A_CTRL) chk("R2 ctrl read", rd_data, erd);
      else if (a == A_STAT && erd[4+:4] !== 4'bx && m_ctrl[4] == 1'b0 && !(wr && a == A_CTRL))
        chk("R4 R5 R6 R7 status read", rd_data, erd);
      else if (a == A_STAT) chk("R8 status read", rd_data, erd);
      else chk("R11 unused read", rd_data, erd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd20240611);
    m_ctrl = 5'b01000; m_st = 4'b1011; m_dl = 4'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pins after reset", {pin_out2, pin_out1, pin_rts, pin_dtr}, 4'b1000);
    chk("R1 irq after reset", irq, 1'b0);
    step(0, 1, A_CTRL, 0, 4'b1011, 0);
    chk("R1 ctrl reset value", rd_data, 8'h08);
    step(0, 1, A_STAT, 0, 4'b1011, 0);
    chk("R1 status reset value", rd_data, 8'hB0);
    // R2 upper bits dropped, R9 loopback pins
    step(1, 0, A_CTRL, 8'hFF, 4'b1011, 0);
    step(0, 1, A_CTRL, 0, 4'b1011, 0);
    chk("R2 ctrl keeps 5 bits", rd_data, 8'h1F);
    // R3 outputs follow
    step(1, 0, A_CTRL, 8'h0F, 4'b1011, 0);
    step(1, 0, A_CTRL, 8'h05, 4'b1011, 0);
    // R5 CTS change sets flag and irq
    step(0, 0, A_CTRL, 0, 4'b1010, 1);
    chk("R10 irq on cts flag", irq, 1'b1);
    step(0, 1, A_STAT, 0, 4'b1010, 1);
    chk("R5 cts flag", rd_data, 8'hA1);
    chk("R7 irq gone after read", irq, 1'b0);
    // R6 ring rise then fall
    step(0, 0, A_CTRL, 0, 4'b1110, 1);
    chk("R6 no flag on ring rise", irq, 1'b0);
    step(0, 0, A_CTRL, 0, 4'b1010, 1);
    step(0, 1, A_STAT, 0, 4'b1010, 1);
    chk("R6 flag on ring fall", rd_data, 8'hA4);
    // R7 read collides with DSR change
    step(0, 1, A_STAT, 0, 4'b1000, 1);
    chk("R7 read returns pre-edge", rd_data, 8'hA0);
    step(0, 1, A_STAT, 0, 4'b1000, 1);
    chk("R7 new change survives read", rd_data, 8'h82);
    // R8 loopback mapping and freezing
    step(1, 0, A_CTRL, 8'h15, 4'b1000, 1);
    step(0, 1, A_STAT, 0, 4'b0111, 1);
    chk("R8 loopback read", rd_data, 8'h60);
    step(1, 0, A_CTRL, 8'h1A, 4'b0111, 1);
    step(0, 1, A_STAT, 0, 4'b0111, 1);
    chk("R8 loopback read 2", rd_data, 8'h90);
    step(1, 0, A_CTRL, 8'h00, 4'b1000, 1);
    step(0, 1, A_STAT, 0, 4'b1000, 1);
    chk("R8 state frozen through loopback", rd_data, 8'h80);
    // R11 ignored writes and unused reads
    step(1, 0, A_STAT, 8'hFF, 4'b1000, 0);
    step(1, 0, 2'd2, 8'hFF, 4'b1000, 0);
    step(0, 1, A_CTRL, 0, 4'b1000, 0);
    chk("R11 ctrl untouched", rd_data, 8'h00);
    step(0, 1, A_STAT, 0, 4'b1000, 0);
    chk("R11 status untouched", rd_data, 8'h80);
    step(0, 1, 2'd3, 0, 4'b1000, 0);
    chk("R11 unused reads zero", rd_data, 8'h00);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [3:0] ln;
      r = $urandom;
      ln = (r[3:0] < 4'd10) ? m_st : r[7:4];
      if (m_ctrl[4]) ln = r[7:4];
      step(r[8] & r[9], r[10] | r[11], r[13:12], r[23:16] & {3'b111, r[24] & r[25] & r[26], 4'hF},
           ln, r[27] | r[28]);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule